// File: doc/BRIEF.md
# Hashed Segment Detection Module

This block scans a byte stream for short pattern segments of one to eight bytes. Each arriving byte is used directly as the address into a 256-entry table. An entry holds a segment, its length, and the position inside the segment at which the addressing byte must sit. The looked-up segment is compared against a sliding window of stream bytes placed around that byte. When the compare succeeds, the table address is reported together with the entry's two-bit kind.

Segments may be keyed on any of their bytes. The detection moment therefore depends on the entry's key offset. A per-report switched delay line removes that dependence: every hit leaves the block a fixed number of cycles after the first byte of its segment entered, so reports come out in stream order.

The table is loaded through a plain write port. After reset a small controller clears the table. It has two named states: ST_WIPE, which writes an empty entry to one address per cycle, and ST_LIVE, the normal operating state. The single transition, wipe-done, is taken from ST_WIPE to ST_LIVE when the last address has been cleared. ST_LIVE is never left until the next reset.

Top module: `hseg_detect`

## Requirements
- R1: After reset, `ready` is low and the table is cleared one address per cycle. `ready` goes high on the 256th rising edge after reset is released and stays high. Writes presented while `ready` is low are dropped, and `hit_valid` stays low while `ready` is low.
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`. The fields are: bits 71:70 hold the kind, bits 69:67 the length, bits 66:64 the key offset, and bits 8i+7:8i hold segment byte i. A later write to the same address replaces the entry.
- R3: Let a byte K be sampled at stream position k, and let the entry at address K have length L and offset O. That entry matches when the L stream bytes at positions k-O through k-O+L-1 equal segment bytes 0 through L-1 in order. A mismatch in any of these bytes gives no hit.
- R4: An entry whose kind field is 0 never produces a hit, whatever the stream holds.
- R5: An entry whose offset is not smaller than its effective length never produces a hit.
- R6: A length field of 0 means eight bytes. A hit for a segment whose first byte was sampled on rising edge s is shown on the outputs right after rising edge s+16. It carries `hit_index` equal to the key byte and `hit_kind` equal to the entry's kind field. Hits therefore leave in order of segment start.
- R7: When two hits share the same segment start, only one is reported. The entry with the greater effective length wins. On equal length, the entry with the smaller key offset wins.
- R8: A stream byte sampled with `in_valid` low can neither serve as a key nor be part of a compared segment.
- R9: `hit_valid` is high for exactly one cycle per reported hit. While `hit_valid` is low, `hit_index` and `hit_kind` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Stream byte present this cycle |
| in_byte | input | 8 | Stream byte |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | 8 | Table address to write |
| wr_data | input | 72 | Entry: kind, length, offset, segment bytes |
| ready | output | 1 | Table clear finished, block operating |
| hit_valid | output | 1 | Hit report present |
| hit_index | output | 8 | Table address of the reporting entry |
| hit_kind | output | 2 | Kind field of the reporting entry |

## Verification
The bench uses segments keyed at offset 0, at a middle offset, and at offset 7 with the length field at 0, and checks that every hit lands exactly sixteen cycles after its start byte. A design with a wrong delay-line tap would report early or late, or swap the order of neighbouring hits. The bench also covers:
- an entry whose offset lies past its length but whose stored bytes do match the stream, which catches a design that skips the bound test;
- a gap in `in_valid` inside an otherwise matching segment;
- an empty-kind entry;
- a write dropped during the clear;
- two same-start collisions, one between unequal lengths and one between equal lengths, which expose a design that keeps the wrong winner or emits two reports.

// File: rtl/hseg_pkg.sv
package hseg_pkg;

    localparam int SEG_BYTES = 8;                      // longest segment
    localparam int KEY_W     = 8;                      // key is one stream byte
    localparam int TYPE_W    = 2;
    localparam int DEPTH     = 1 << KEY_W;
    localparam int FLD_W     = $clog2(SEG_BYTES);      // length and offset fields
    localparam int DATA_W    = 8 * SEG_BYTES;
    localparam int ENTRY_W   = TYPE_W + 2 * FLD_W + DATA_W;
    localparam int WIN       = 2 * SEG_BYTES;          // stream window depth
    localparam int KEY_POS   = SEG_BYTES;              // key byte slot at compare time
    localparam int LATENCY   = 2 * SEG_BYTES;          // start byte to report

    typedef logic [7:0] octet_t;

    typedef struct packed {
        logic [TYPE_W-1:0] kind;
        logic [FLD_W-1:0]  len;
        logic [FLD_W-1:0]  off;
        logic [DATA_W-1:0] seg;
    } entry_t;

    typedef struct packed {
        logic              valid;
        logic [KEY_W-1:0]  idx;
        logic [TYPE_W-1:0] kind;
        logic [FLD_W:0]    span;
    } report_t;

    // length field 0 encodes a full segment
    function automatic logic [FLD_W:0] span_of(logic [FLD_W-1:0] len);
        return (len == '0) ? (FLD_W + 1)'(SEG_BYTES) : {1'b0, len};
    endfunction

endpackage

// File: rtl/hseg_table.sv
module hseg_table
    import hseg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_addr,
    input  entry_t           wr_data,
    input  logic [KEY_W-1:0] rd_addr,
    output entry_t           rd_q,
    output logic             live
);

    typedef enum logic {ST_WIPE, ST_LIVE} tab_state_t;

    tab_state_t       state_q, state_d;
    logic [KEY_W-1:0] wipe_q;
    entry_t           mem [DEPTH];

    // next state: wipe-done when the last address is being cleared
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WIPE: if (wipe_q == KEY_W'(DEPTH - 1)) state_d = ST_LIVE;
            ST_LIVE: state_d = ST_LIVE;
            default: state_d = ST_WIPE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_WIPE;
            wipe_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WIPE) wipe_q <= wipe_q + 1'b1;
        end
    end

    always_comb begin
        live = (state_q == ST_LIVE);
    end

    // storage: clear sweep has the port while wiping, host writes after
    always_ff @(posedge clk) begin
        if (state_q == ST_WIPE)
            mem[wipe_q] <= '0;
        else if (wr_en)
            mem[wr_addr] <= wr_data;
        rd_q <= mem[rd_addr];
    end

    p_live_holds_r1: assert property (@(posedge clk) disable iff (rst)
        live |=> live);

endmodule

// File: rtl/hseg_window.sv
module hseg_window
    import hseg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  octet_t         in_byte,
    output octet_t         win [WIN],
    output logic [WIN-1:0] vld
);

    // slot 0 holds the newest byte
    always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= {vld[WIN-2:0], in_valid};
    end

    always_ff @(posedge clk) begin
        win[0] <= in_byte;
        for (int i = 1; i < WIN; i++) win[i] <= win[i-1];
    end

endmodule

// File: rtl/hseg_match.sv
module hseg_match
    import hseg_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           live,
    input  entry_t         ent,
    input  octet_t         win [WIN],
    input  logic [WIN-1:0] vld,
    output logic           hit,
    output logic [FLD_W:0] span
);

    logic eq;

    // segment byte i sits at window slot KEY_POS + off - i
    always_comb begin
        span = span_of(ent.len);
        eq   = 1'b1;
        for (int i = 0; i < SEG_BYTES; i++) begin
            if (i < int'(span)) begin
                if (!vld[KEY_POS + int'(ent.off) - i] ||
                    (win[KEY_POS + int'(ent.off) - i] != ent.seg[8*i +: 8]))
                    eq = 1'b0;
            end
        end
        hit = live && (ent.kind != '0) && ({1'b0, ent.off} < span) && eq;
    end

    p_key_present_r8: assert property (@(posedge clk) disable iff (rst)
        hit |-> vld[KEY_POS]);

    p_key_in_seg_r3: assert property (@(posedge clk) disable iff (rst)
        hit |-> (win[KEY_POS] == ent.seg[8*int'(ent.off) +: 8]));

endmodule

// File: rtl/hseg_retime.sv
module hseg_retime
    import hseg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [KEY_W-1:0]  ins_idx,
    input  logic [TYPE_W-1:0] ins_kind,
    input  logic [FLD_W-1:0]  ins_off,
    input  logic [FLD_W:0]    ins_span,
    output logic              hit_valid,
    output logic [KEY_W-1:0]  hit_index,
    output logic [TYPE_W-1:0] hit_kind
);

    report_t          slot_q [SEG_BYTES];
    report_t          slot_d [SEG_BYTES];
    logic [FLD_W-1:0] tgt;

    // shift toward slot 0; insert at depth (max offset - offset)
    always_comb begin
        for (int p = 0; p < SEG_BYTES - 1; p++) slot_d[p] = slot_q[p+1];
        slot_d[SEG_BYTES-1] = '0;
        tgt = FLD_W'(SEG_BYTES - 1) - ins_off;
        if (ins_valid && (!slot_d[tgt].valid || (ins_span > slot_d[tgt].span)))
            slot_d[tgt] = '{valid: 1'b1, idx: ins_idx, kind: ins_kind, span: ins_span};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int p = 0; p < SEG_BYTES; p++) slot_q[p] <= '0;
        end else begin
            for (int p = 0; p < SEG_BYTES; p++) slot_q[p] <= slot_d[p];
        end
    end

    always_comb begin
        hit_valid = slot_q[0].valid;
        hit_index = slot_q[0].idx;
        hit_kind  = slot_q[0].kind;
    end

    p_kind_set_r4: assert property (@(posedge clk) disable iff (rst)
        hit_valid |-> (hit_kind != '0));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !hit_valid |-> ((hit_index == '0) && (hit_kind == '0)));

endmodule

// File: rtl/hseg_detect.sv
module hseg_detect
    import hseg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    input  logic               wr_en,
    input  logic [KEY_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    output logic               ready,
    output logic               hit_valid,
    output logic [KEY_W-1:0]   hit_index,
    output logic [TYPE_W-1:0]  hit_kind
);

    octet_t         win [WIN];
    logic [WIN-1:0] vld;
    entry_t         ent;
    logic           live;
    logic           cmp_hit;
    logic [FLD_W:0] cmp_span;

    hseg_window u_win (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .win      (win),
        .vld      (vld)
    );

    // key is read one slot early so the entry arrives with it at KEY_POS
    hseg_table u_tab (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (entry_t'(wr_data)),
        .rd_addr (win[KEY_POS-1]),
        .rd_q    (ent),
        .live    (live)
    );

    hseg_match u_cmp (
        .clk  (clk),
        .rst  (rst),
        .live (live),
        .ent  (ent),
        .win  (win),
        .vld  (vld),
        .hit  (cmp_hit),
        .span (cmp_span)
    );

    hseg_retime u_rt (
        .clk       (clk),
        .rst       (rst),
        .ins_valid (cmp_hit),
        .ins_idx   (win[KEY_POS]),
        .ins_kind  (ent.kind),
        .ins_off   (ent.off),
        .ins_span  (cmp_span),
        .hit_valid (hit_valid),
        .hit_index (hit_index),
        .hit_kind  (hit_kind)
    );

    always_comb begin
        ready = live;
    end

    p_quiet_wipe_r1: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !hit_valid);

endmodule

// File: tb/sim_hseg_detect.sv
`timescale 1ns/1ps
module sim_hseg_detect;

    localparam int LAT = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [71:0] wr_data = '0;
    logic        ready, hit_valid;
    logic [7:0]  hit_index;
    logic [1:0]  hit_kind;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    typedef struct {
        int    at;
        int    idx;
        int    kind;
        string tag;
    } exp_t;
    exp_t exq[$];

    always #2 clk = ~clk;              // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    hseg_detect u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ready(ready), .hit_valid(hit_valid), .hit_index(hit_index), .hit_kind(hit_kind)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [71:0] mk(int kind, int len, int off, string s);
        logic [71:0] w;
        w = '0;
        w[71:70] = kind[1:0];
        w[69:67] = len[2:0];
        w[66:64] = off[2:0];
        for (int i = 0; i < s.len(); i++) w[8*i +: 8] = s[i];
        return w;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [71:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive a string back to back; st is the edge that samples its first byte
    task automatic send(input string s, output int st);
        st = 0;
        for (int i = 0; i < s.len(); i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_byte = s[i];
            if (i == 0) st = cyc + 1;
        end
        @(negedge clk);
        in_valid = 1'b0; in_byte = '0;
    endtask

    task automatic expect_hit(input int st, input int idx, input int kind, input string tag);
        exp_t e;
        e.at = st + LAT; e.idx = idx; e.kind = kind; e.tag = tag;
        exq.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (hit_valid) begin
                if (exq.size() == 0 || exq[0].at != cyc) begin
                    checks++; fails++;
                    $display("FAIL %s unexpected hit idx=%0h kind=%0d at cycle %0d expected none",
                             cur_tag, hit_index, hit_kind, cyc);
                end else begin
                    check(hit_index == exq[0].idx[7:0], exq[0].tag, "hit_index",
                          int'(hit_index), exq[0].idx);
                    check(hit_kind == exq[0].kind[1:0], exq[0].tag, "hit_kind",
                          int'(hit_kind), exq[0].kind);
                    void'(exq.pop_front());
                end
            end else begin
                check(hit_index == 8'h0 && hit_kind == 2'h0, "R9", "idle outputs",
                      int'({hit_index, hit_kind}), 0);
                if (exq.size() != 0 && exq[0].at <= cyc) begin
                    checks++; fails++;
                    $display("FAIL %s missing hit idx=%0h actual=none expected at cycle %0d",
                             exq[0].tag, exq[0].idx, exq[0].at);
                    void'(exq.pop_front());
                end
            end
        end
    end

    initial begin
        int c0, st;
        repeat (4) @(negedge clk);
        check(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
        check(hit_valid == 1'b0, "R9", "hit_valid in reset", int'(hit_valid), 0);
        rst = 1'b0;
        c0 = cyc;
        idle(100);
        check(ready == 1'b0, "R1", "ready mid wipe", int'(ready), 0);
        wr(8'h05, mk(1, 1, 0, "\x05"));          // dropped: table still clearing
        while (!ready) @(negedge clk);
        check(cyc - c0 == 256, "R1", "edges until ready", cyc - c0, 256);

        cur_tag = "R1";
        send("\x05", st);                        // no expectation
        idle(20);

        wr("A", mk(1, 3, 0, "ABC"));
        wr("Q", mk(2, 4, 2, "XYQZ"));
        wr("h", mk(3, 0, 7, "abcdefgh"));
        wr("T", mk(0, 2, 0, "TU"));
        wr("U", mk(1, 2, 3, "GH"));
        wr("m", mk(1, 2, 0, "mn"));
        wr("n", mk(2, 3, 1, "mno"));
        wr("p", mk(1, 2, 0, "pq"));
        wr("q", mk(3, 2, 1, "pq"));

        cur_tag = "R3";
        send("xxABCxx", st);  expect_hit(st + 2, 8'h41, 1, "R3 key at offset 0");
        idle(20);
        send("ABD", st);      idle(20);          // R3: last byte differs
        send("XYQZ", st);     expect_hit(st, 8'h51, 2, "R3 key at offset 2");
        idle(20);

        cur_tag = "R6";
        send("abcdefgh", st); expect_hit(st, 8'h68, 3, "R6 length 0 offset 7");
        idle(20);
        send("XYQZABC", st);
        expect_hit(st, 8'h51, 2, "R6 order first");
        expect_hit(st + 4, 8'h41, 1, "R6 order second");
        idle(20);
        send("abcdefghABC", st);
        expect_hit(st, 8'h68, 3, "R6 late key first");
        expect_hit(st + 8, 8'h41, 1, "R6 early key second");
        idle(20);
        send("ABCABC", st);
        expect_hit(st, 8'h41, 1, "R9 pulse one");
        expect_hit(st + 3, 8'h41, 1, "R9 pulse two");
        idle(20);

        cur_tag = "R4";
        send("TU", st);   idle(20);
        cur_tag = "R5";
        send("GHxU", st); idle(20);

        cur_tag = "R8";
        @(negedge clk); in_valid = 1'b1; in_byte = "A";
        @(negedge clk); in_byte = "B";
        @(negedge clk); in_valid = 1'b0; in_byte = "X";
        @(negedge clk); in_valid = 1'b1; in_byte = "C";
        @(negedge clk); in_valid = 1'b0; in_byte = "A";   // invalid key byte
        @(negedge clk); in_byte = "B";
        @(negedge clk); in_byte = "C";
        @(negedge clk); in_byte = '0;
        idle(20);

        cur_tag = "R7";
        send("mno", st); expect_hit(st, 8'h6e, 2, "R7 longer wins");
        idle(20);
        send("pq", st);  expect_hit(st, 8'h70, 1, "R7 tie smaller offset wins");
        idle(20);

        cur_tag = "R2";
        wr("A", mk(0, 3, 0, "ABC"));
        send("ABC", st); idle(20);
        wr("A", mk(2, 3, 0, "ABC"));
        send("ABC", st); expect_hit(st, 8'h41, 2, "R2 rewritten entry");
        idle(30);

        check(exq.size() == 0, "R6", "outstanding expectations", exq.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule